// File: doc/BRIEF.md
# Toggle Handshake Word Crossing

This block carries one data word at a time from a source clock domain to a destination clock domain. The two clocks have no phase relationship. Typical rates are 33 MHz at the source and 20 MHz at the destination. The source loads the word into a holding register and inverts a single request flag. The destination sees that flag through a synchroniser, notices that it differs from its own last-seen copy, and updates that copy. It then reads the holding register, which has been stable for at least two destination cycles, and reports the word with a one-cycle valid pulse.

After the capture, the destination inverts an acknowledge flag. That flag returns to the source through a second synchroniser. The source reports itself busy from the moment it accepts a word until the acknowledge matches the request again. While busy it ignores any send strobe. Two request toggles therefore cannot cancel each other, and the holding register cannot change while the destination is reading it. Each domain has its own synchronous active-high reset, and every flag resets to 0.

Top module: `tog_xfer`

## Requirements
- R1: After reset, `src_ready` is 1 and `dst_valid` is 0. With no send strobe, no valid pulse ever appears, because the request flag, the last-seen flag and the acknowledge flag all reset to 0.
- R2: A cycle with `src_send`=1 while `src_ready`=1 accepts `src_data`. `src_ready` is 0 from the next source clock edge on.
- R3: A `src_send` strobe while `src_ready`=0 is ignored. Its data is never delivered, and it does not disturb the word in flight.
- R4: Every accepted word appears on `dst_data` exactly once, unchanged, together with `dst_valid`=1.
- R5: Words arrive in the order in which they were accepted.
- R6: `src_ready` returns to 1 only after the valid pulse for the accepted word has been issued.
- R7: `dst_valid` is never high for two consecutive destination cycles.
- R8: `dst_data` holds the last delivered word between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_send | input | 1 | Send strobe; a word is accepted only when src_ready is 1 |
| src_data | input | WIDTH | Word to send |
| src_ready | output | 1 | 1 when a new word can be accepted |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_valid | output | 1 | One-cycle pulse marking a delivered word |
| dst_data | output | WIDTH | Delivered word, held between pulses |

## Verification
The bench sends every one of the 256 byte values. The gaps between words vary, and many words are sent back to back the moment ready returns. A design that lets a second toggle through before the acknowledge returns would drop or duplicate words, and the in-order compare catches that. Strobes with inverted data are driven while the block is busy. A design that accepted them would deliver the wrong word or change the holding register in mid-read. The bench also waits idle after reset to catch a false first detection, checks that every valid pulse lasts one cycle, and checks that the data output holds between pulses.

// File: rtl/tog_xfer_pkg.sv
package tog_xfer_pkg;
  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_READ = 1'b1
  } rx_state_t;
endpackage

// File: rtl/tog_sync.sv
module tog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tog_src.sv
module tog_src #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             send,
  input  logic [WIDTH-1:0] data,
  input  logic             ack_async,
  output logic             req_flag,
  output logic [WIDTH-1:0] hold,
  output logic             ready
);
  logic             req_q;
  logic             busy_q;
  logic [WIDTH-1:0] hold_q;
  logic             ack_s;
  logic             accept;

  tog_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_async), .q(ack_s)
  );

  assign accept = send && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      hold_q <= '0;
    end else if (accept) begin
      hold_q <= data;
      req_q  <= ~req_q;
      busy_q <= 1'b1;
    end else if (busy_q && (ack_s == req_q)) begin
      busy_q <= 1'b0;
    end
  end

  assign req_flag = req_q;
  assign hold     = hold_q;
  assign ready    = !busy_q;

  // R2: an accepted strobe flips the request flag
  a_r2_toggle_on_accept: assert property (@(posedge clk) disable iff (rst)
    (send && ready) |=> (req_q != $past(req_q)) && !ready);

  // R3: strobes while busy leave the flag and the holding register alone
  a_r3_busy_ignores_send: assert property (@(posedge clk) disable iff (rst)
    (send && !ready) |=> $stable(req_q) && $stable(hold_q));

  // R6: ready only comes back once the returned flag matches
  a_r6_ready_needs_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (ack_s == req_q));
endmodule

// File: rtl/tog_dst.sv
module tog_dst
  import tog_xfer_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_async,
  input  logic [WIDTH-1:0] hold,
  output logic             ack_flag,
  output logic             valid,
  output logic [WIDTH-1:0] data
);
  rx_state_t        state_q;
  logic             seen_q;
  logic             ack_q;
  logic             valid_q;
  logic [WIDTH-1:0] data_q;
  logic             req_s;

  tog_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_async), .q(req_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      seen_q  <= 1'b0;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (req_s != seen_q) begin
            seen_q  <= ~seen_q;
            state_q <= RX_READ;
          end
        end
        RX_READ: begin
          data_q  <= hold;
          valid_q <= 1'b1;
          ack_q   <= seen_q;
          state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign ack_flag = ack_q;
  assign valid    = valid_q;
  assign data     = data_q;

  // R7: a valid pulse lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R4: a pulse is issued together with the acknowledge for that word
  a_r4_pulse_with_ack: assert property (@(posedge clk) disable iff (rst)
    valid |-> (ack_q == seen_q));

  // R8: data only moves alongside a valid pulse
  a_r8_data_held: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (valid || $stable(data_q)));
endmodule

// File: rtl/tog_xfer.sv
module tog_xfer #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic             src_send,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_ready,
  input  logic             dst_clk,
  input  logic             dst_rst,
  output logic             dst_valid,
  output logic [WIDTH-1:0] dst_data
);
  logic             req_flag;
  logic             ack_flag;
  logic [WIDTH-1:0] hold;

  tog_src #(.WIDTH(WIDTH), .STAGES(STAGES)) u_src (
    .clk(src_clk), .rst(src_rst), .send(src_send), .data(src_data),
    .ack_async(ack_flag), .req_flag(req_flag), .hold(hold), .ready(src_ready)
  );

  tog_dst #(.WIDTH(WIDTH), .STAGES(STAGES)) u_dst (
    .clk(dst_clk), .rst(dst_rst), .req_async(req_flag), .hold(hold),
    .ack_flag(ack_flag), .valid(dst_valid), .data(dst_data)
  );
endmodule

// File: tb/sim_tog_xfer.sv
`timescale 1ns/1ps
module sim_tog_xfer;
  localparam int W = 8;
  localparam int NWORDS = 256;

  logic         src_clk = 0, dst_clk = 0;
  logic         src_rst = 1, dst_rst = 1;
  logic         src_send = 0;
  logic [W-1:0] src_data = '0;
  logic         src_ready;
  logic         dst_valid;
  logic [W-1:0] dst_data;

  int errors = 0, checks = 0;
  logic [W-1:0] exp_mem [0:1023];
  int wr_n = 0, rd_n = 0;
  bit done = 0;

  always #15 src_clk = ~src_clk;
  always #25 dst_clk = ~dst_clk;

  tog_xfer #(.WIDTH(W), .STAGES(2)) u0 (
    .src_clk(src_clk), .src_rst(src_rst), .src_send(src_send),
    .src_data(src_data), .src_ready(src_ready),
    .dst_clk(dst_clk), .dst_rst(dst_rst),
    .dst_valid(dst_valid), .dst_data(dst_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Receiver: R4, R5, R7, R8, unexpected pulses for R1/R3
  logic [W-1:0] last_data;
  bit prev_valid = 0;
  always @(negedge dst_clk) begin
    if (!dst_rst) begin
      if (prev_valid) check(!dst_valid, "R7 pulse width", int'(dst_valid), 0);
      if (dst_valid) begin
        if (rd_n >= wr_n) begin
          check(0, "R1/R3 unexpected word", int'(dst_data), -1);
        end else begin
          check(dst_data == exp_mem[rd_n], "R4 R5 word value/order",
                int'(dst_data), int'(exp_mem[rd_n]));
          rd_n++;
        end
        last_data = dst_data;
      end else if (rd_n > 0) begin
        check(dst_data == last_data, "R8 data held", int'(dst_data), int'(last_data));
      end
      prev_valid = dst_valid;
    end
  end

  task automatic send_word(input logic [W-1:0] v, input bit poke, input int gap);
    while (!src_ready) @(negedge src_clk);
    src_send = 1; src_data = v;
    exp_mem[wr_n] = v;
    wr_n++;
    @(negedge src_clk);
    src_send = 0;
    check(!src_ready, "R2 ready drops", int'(src_ready), 0);
    if (poke) begin
      src_send = 1; src_data = ~v;
      @(negedge src_clk);
      src_send = 0;
    end
    while (!src_ready) @(negedge src_clk);
    check(rd_n == wr_n, "R6 ready after delivery", rd_n, wr_n);
    repeat (gap) @(negedge src_clk);
  endtask

  initial begin
    repeat (3) @(negedge dst_clk);
    src_rst = 0; dst_rst = 0;
    @(negedge src_clk);
    check(src_ready == 1, "R1 ready after reset", int'(src_ready), 1);
    check(dst_valid == 0, "R1 valid after reset", int'(dst_valid), 0);
    repeat (40) @(negedge src_clk);
    check(rd_n == 0, "R1 no spurious word", rd_n, 0);
    for (int i = 0; i < NWORDS; i++)
      send_word(W'(i * 37 + 5), (i % 3) == 0, (i % 5 == 0) ? int'($urandom_range(0, 6)) : 0);
    repeat (20) @(negedge dst_clk);
    check(rd_n == NWORDS, "R3 R4 delivered count", rd_n, NWORDS);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge src_clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule